// File: doc/BRIEF.md
# Gain-Range Selecting Output Multiplexer

This block sits behind three parallel digitizers that convert the same input sample at high, medium and low gain. Each sample period it receives one 12-bit word from each range. It sends two of those words, one after the other, over a single 12-bit output bus that runs at twice the sample rate. The medium-gain word always occupies the first slot. The second slot carries the high-gain word if the high-gain sample is below a programmable saturation threshold. If the high-gain sample is at or above the threshold, the second slot carries the low-gain word instead, and a range tag marks the substitution.

The block runs entirely on the double-rate clock. A sample-valid strobe, one clock wide, marks the cycle in which the three input words are valid. The block captures all three words at that strobe, and it makes the range decision at the same edge. Both output slots therefore describe the same sample, and a threshold change never splits a pair. Strobes normally arrive every second clock. This keeps the output bus busy without gaps.

Top module: `gain_slot_mux`

## Requirements
- R1: While `rst_n` is low, and after reset until the first accepted sample has reached the output, `out_word` is 0 and `out_slot` and `out_lowtag` are 0.
- R2: When a strobe is accepted at clock edge P, the edge P+1 drives `out_word` to the medium-gain word of that sample, with `out_slot` = 0 and `out_lowtag` = 0.
- R3: At edge P+2, `out_word` carries the high-gain word if it is strictly below the threshold, otherwise the low-gain word, and `out_slot` = 1. The medium-gain word never appears in this slot.
- R4: `out_lowtag` is 1 only in a second slot that carries the low-gain word. It is 0 in all other cycles.
- R5: The threshold register resets to 12'hFFF. A cycle with `thr_wr` = 1 loads `thr_val` at that edge. With the reset value, only a high-gain word of 12'hFFF counts as saturated.
- R6: The range decision uses the threshold held in the register at the capture edge. A threshold write in the same cycle as a strobe applies only to later samples.
- R7: Input words that change after the capture edge have no effect on the two slots of the captured sample.
- R8: A strobe in the cycle right after an accepted strobe is ignored. The pair already in progress completes unchanged, and no further pair follows it.
- R9: Strobes every second clock give an unbroken output stream. First and second slots alternate, and each pair belongs to one sample.
- R10: If no new strobe has been accepted by the time a second slot is emitted, the next cycle returns `out_word` to 0 and `out_slot` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock (twice the sample rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | One-cycle strobe marking valid input words |
| sample_hi | input | 12 | High-gain (most sensitive) sample |
| sample_mid | input | 12 | Medium-gain sample |
| sample_lo | input | 12 | Low-gain sample |
| thr_wr | input | 1 | Load strobe for the saturation threshold |
| thr_val | input | 12 | New saturation threshold value |
| out_word | output | 12 | Time-shared output word |
| out_slot | output | 1 | High during the second slot of a pair |
| out_lowtag | output | 1 | High when the second slot carries the low-gain word |

## Verification
The hardest case to reach from the ports is a threshold write that lands in the same cycle as a sample strobe. The register takes the new value at the same edge that makes the decision, so a design that compares against the incoming value differs only in that one cycle. The stimulus sends a strobe and a write together, with a high-gain word that sits between the old threshold and the new one. It then sends the same word again one pair later and expects the opposite choice. A strobe one cycle after another is also driven to show that the pair already in flight stays intact.

// File: rtl/gsm_pkg.sv
// Package: shared types for the gain-range slot multiplexer.
// Assumes: the output sequencer has three states; nothing else is shared.
package gsm_pkg;

    // Output sequencer state: idle, first (medium) slot, second (selected) slot
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_FIRST  = 2'd1,
        SEQ_SECOND = 2'd2
    } seq_state_t;

endpackage

// File: rtl/gsm_thresh_reg.sv
// Module: gsm_thresh_reg
// Holds the saturation threshold for the high-gain range.
// Assumes: the write strobe is synchronous to clk; the reset value is all ones,
// so only a full-scale high-gain word counts as saturated.
module gsm_thresh_reg #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_val,
    output logic [DATA_W-1:0] thr_q
);

    localparam logic [DATA_W-1:0] THR_RESET = {DATA_W{1'b1}};

    // Load a new threshold on write, return to full scale on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= THR_RESET;
        end else if (wr_en) begin
            thr_q <= wr_val;
        end
    end

endmodule

// File: rtl/gsm_capture.sv
// Module: gsm_capture
// Latches the three range samples on an accepted strobe. At the same edge it
// decides the second-slot word, so that both slots come from one sample and
// the threshold used is the one held at capture time.
// Assumes: strobes are at least two cycles apart; a strobe in the cycle
// straight after an accepted one is dropped so the pair in progress survives.
module gsm_capture #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [DATA_W-1:0] in_hi,
    input  logic [DATA_W-1:0] in_mid,
    input  logic [DATA_W-1:0] in_lo,
    input  logic [DATA_W-1:0] thr_q,
    output logic              cap_new,
    output logic [DATA_W-1:0] cap_mid,
    output logic [DATA_W-1:0] cap_sel,
    output logic              cap_uselow
);

    logic accept;
    logic saturated;

    // Saturation test of the most sensitive range against the stored threshold
    always_comb begin
        saturated = (in_hi >= thr_q);
    end

    // Accept a strobe only when no capture happened on the previous edge
    always_comb begin
        accept = strobe && !cap_new;
    end

    // Mark the cycle that follows a capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_new <= 1'b0;
        end else begin
            cap_new <= accept;
        end
    end

    // Store the first-slot word and the already-chosen second-slot word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_mid    <= '0;
            cap_sel    <= '0;
            cap_uselow <= 1'b0;
        end else if (accept) begin
            cap_mid    <= in_mid;
            cap_sel    <= saturated ? in_lo : in_hi;
            cap_uselow <= saturated;
        end
    end

endmodule

// File: rtl/gsm_slot_seq.sv
// Module: gsm_slot_seq
// Drives the shared output bus at the double rate. After each capture it
// emits the medium word, then the selected word with the slot marker high,
// then returns to zero unless another capture has arrived.
// Assumes: cap_new never sits high in two consecutive cycles.
module gsm_slot_seq
    import gsm_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_new,
    input  logic [DATA_W-1:0] cap_mid,
    input  logic [DATA_W-1:0] cap_sel,
    input  logic              cap_uselow,
    output logic [DATA_W-1:0] out_word,
    output logic              out_slot,
    output logic              out_lowtag
);

    seq_state_t state_q;

    // Step through first slot, second slot and idle, registering every output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_IDLE;
            out_word   <= '0;
            out_slot   <= 1'b0;
            out_lowtag <= 1'b0;
        end else if (cap_new) begin
            state_q    <= SEQ_FIRST;
            out_word   <= cap_mid;
            out_slot   <= 1'b0;
            out_lowtag <= 1'b0;
        end else if (state_q == SEQ_FIRST) begin
            state_q    <= SEQ_SECOND;
            out_word   <= cap_sel;
            out_slot   <= 1'b1;
            out_lowtag <= cap_uselow;
        end else begin
            state_q    <= SEQ_IDLE;
            out_word   <= '0;
            out_slot   <= 1'b0;
            out_lowtag <= 1'b0;
        end
    end

endmodule

// File: rtl/gain_slot_mux.sv
// Module: gain_slot_mux (top)
// Time-shares one output bus between the medium-gain word and either the
// high- or the low-gain word, chosen from saturation of the high-gain range.
// Assumes: clk runs at twice the sample rate; sample_valid is one cycle wide.
module gain_slot_mux #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [DATA_W-1:0] sample_hi,
    input  logic [DATA_W-1:0] sample_mid,
    input  logic [DATA_W-1:0] sample_lo,
    input  logic              thr_wr,
    input  logic [DATA_W-1:0] thr_val,
    output logic [DATA_W-1:0] out_word,
    output logic              out_slot,
    output logic              out_lowtag
);

    logic [DATA_W-1:0] thr_q;
    logic              cap_new;
    logic [DATA_W-1:0] cap_mid;
    logic [DATA_W-1:0] cap_sel;
    logic              cap_uselow;

    gsm_thresh_reg #(.DATA_W(DATA_W)) u_thr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (thr_wr),
        .wr_val (thr_val),
        .thr_q  (thr_q)
    );

    gsm_capture #(.DATA_W(DATA_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (sample_valid),
        .in_hi      (sample_hi),
        .in_mid     (sample_mid),
        .in_lo      (sample_lo),
        .thr_q      (thr_q),
        .cap_new    (cap_new),
        .cap_mid    (cap_mid),
        .cap_sel    (cap_sel),
        .cap_uselow (cap_uselow)
    );

    gsm_slot_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_new    (cap_new),
        .cap_mid    (cap_mid),
        .cap_sel    (cap_sel),
        .cap_uselow (cap_uselow),
        .out_word   (out_word),
        .out_slot   (out_slot),
        .out_lowtag (out_lowtag)
    );

endmodule

// File: rtl/gsm_checker.sv
// Module: gsm_checker
// Temporal checks on gain_slot_mux, attached through bind below.
// Assumes: reset is synchronous and active low.
module gsm_checker #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [DATA_W-1:0] sample_hi,
    input  logic              thr_wr,
    input  logic [DATA_W-1:0] thr_val,
    input  logic [DATA_W-1:0] thr_q,
    input  logic              cap_new,
    input  logic [DATA_W-1:0] cap_mid,
    input  logic              cap_uselow,
    input  logic [DATA_W-1:0] out_word,
    input  logic              out_slot,
    input  logic              out_lowtag
);

    assert_mid_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_new |=> (!out_slot && !out_lowtag && out_word == $past(cap_mid)));

    assert_second_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_new |-> ##2 out_slot);

    assert_slot_alternates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_slot |=> !out_slot);

    assert_tag_in_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_lowtag |-> out_slot);

    assert_tag_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_slot |-> (out_lowtag == $past(cap_uselow)));

    assert_thr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(thr_wr) |-> (thr_q == $past(thr_val)));

    assert_decision_at_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_new |-> (cap_uselow == ($past(sample_hi) >= $past(thr_q))));

    assert_no_back_to_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_new && sample_valid) |=> !cap_new);

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_slot && !$past(cap_new)) |-> (out_word == '0));

endmodule

bind gain_slot_mux gsm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .sample_hi    (sample_hi),
    .thr_wr       (thr_wr),
    .thr_val      (thr_val),
    .thr_q        (thr_q),
    .cap_new      (cap_new),
    .cap_mid      (cap_mid),
    .cap_uselow   (cap_uselow),
    .out_word     (out_word),
    .out_slot     (out_slot),
    .out_lowtag   (out_lowtag)
);

// File: tb/gain_slot_mux_test.sv
// Bench for gain_slot_mux: vector table walk, then directed corner cases.
module gain_slot_mux_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 12;
    localparam int NVEC = 8;

    // {hi, mid, lo, threshold, expected second word, expected tag}
    localparam logic [60:0] VEC [0:NVEC-1] = '{
        {12'h100, 12'h200, 12'h300, 12'hFFF, 12'h100, 1'b0},
        {12'hFFE, 12'h007, 12'h008, 12'hFFF, 12'hFFE, 1'b0},
        {12'hFFF, 12'h009, 12'h00A, 12'hFFF, 12'h00A, 1'b1},
        {12'h800, 12'h001, 12'h002, 12'h800, 12'h002, 1'b1},
        {12'h7FF, 12'h003, 12'h004, 12'h800, 12'h7FF, 1'b0},
        {12'h000, 12'h005, 12'h006, 12'h000, 12'h006, 1'b1},
        {12'hABC, 12'hDEF, 12'h123, 12'hABD, 12'hABC, 1'b0},
        {12'h000, 12'hFFF, 12'h000, 12'h001, 12'h000, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sample_valid = 1'b0;
    logic [W-1:0] sample_hi = '0;
    logic [W-1:0] sample_mid = '0;
    logic [W-1:0] sample_lo = '0;
    logic         thr_wr = 1'b0;
    logic [W-1:0] thr_val = '0;
    logic [W-1:0] out_word;
    logic         out_slot;
    logic         out_lowtag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gain_slot_mux #(.DATA_W(W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_hi    (sample_hi),
        .sample_mid   (sample_mid),
        .sample_lo    (sample_lo),
        .thr_wr       (thr_wr),
        .thr_val      (thr_val),
        .out_word     (out_word),
        .out_slot     (out_slot),
        .out_lowtag   (out_lowtag)
    );

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    // Check all three outputs at once
    task automatic check_out(string req, int word, int slot, int tag);
        check({req, " word"}, int'(out_word), word);
        check({req, " slot"}, int'(out_slot), slot);
        check({req, " tag"}, int'(out_lowtag), tag);
    endtask

    task automatic drive_sample(logic [W-1:0] h, logic [W-1:0] m, logic [W-1:0] l);
        sample_valid = 1'b1;
        sample_hi = h;
        sample_mid = m;
        sample_lo = l;
    endtask

    task automatic write_thr(logic [W-1:0] t);
        @(negedge clk);
        thr_wr = 1'b1;
        thr_val = t;
        @(negedge clk);
        thr_wr = 1'b0;
    endtask

    // One isolated sample: drive, scramble inputs after capture, check both slots and idle
    task automatic one_pair(logic [W-1:0] h, logic [W-1:0] m, logic [W-1:0] l,
                            logic [W-1:0] exp2, logic tag, string req);
        @(negedge clk);
        drive_sample(h, m, l);
        @(negedge clk);
        sample_valid = 1'b0;
        sample_hi = ~h; sample_mid = ~m; sample_lo = ~l;   // R7: late changes
        @(negedge clk);
        check_out({req, " R2 first slot"}, int'(m), 0, 0);
        @(negedge clk);
        check_out({req, " R3 second slot"}, int'(exp2), 1, int'(tag));
        @(negedge clk);
        check_out({req, " R10 idle"}, 0, 0, 0);
    endtask

    initial begin
        // R1: outputs stay zero in reset and after release
        repeat (3) @(negedge clk);
        check_out("R1 in reset", 0, 0, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_out("R1 after reset", 0, 0, 0);

        // R5: reset threshold full scale
        one_pair(12'hFFE, 12'h011, 12'h022, 12'hFFE, 1'b0, "R5 below reset thr");
        one_pair(12'hFFF, 12'h011, 12'h022, 12'h022, 1'b1, "R5 at reset thr");

        // Table walk: R3, R4, R5, R7
        for (int i = 0; i < NVEC; i++) begin
            write_thr(VEC[i][24:13]);
            one_pair(VEC[i][60:49], VEC[i][48:37], VEC[i][36:25],
                     VEC[i][12:1], VEC[i][0], $sformatf("vec%0d R4", i));
        end

        // R6: write in the strobe cycle applies only to the next sample
        write_thr(12'hFFF);
        @(negedge clk);
        drive_sample(12'h200, 12'h055, 12'h066);
        thr_wr = 1'b1; thr_val = 12'h100;
        @(negedge clk);
        sample_valid = 1'b0; thr_wr = 1'b0;
        @(negedge clk);
        check_out("R6 same-cycle first", 12'h055, 0, 0);
        @(negedge clk);
        check_out("R6 same-cycle old thr", 12'h200, 1, 0);
        one_pair(12'h200, 12'h055, 12'h066, 12'h066, 1'b1, "R6 new thr");

        // R8: strobe right after an accepted one is dropped
        write_thr(12'h800);
        @(negedge clk);
        drive_sample(12'h010, 12'h0A1, 12'h0B1);
        @(negedge clk);
        drive_sample(12'hF00, 12'h0A2, 12'h0B2);
        @(negedge clk);
        sample_valid = 1'b0;
        check_out("R8 first kept", 12'h0A1, 0, 0);
        @(negedge clk);
        check_out("R8 second kept", 12'h010, 1, 0);
        @(negedge clk);
        check_out("R8 no extra pair", 0, 0, 0);

        // R9: strobes every second clock give a gapless stream
        @(negedge clk);
        drive_sample(12'h000, 12'h300, 12'h400);
        @(negedge clk);
        sample_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_out($sformatf("R9 stream %0d first", i), 12'h300 + i, 0, 0);
            if (i < 3) drive_sample(12'h7FE + 12'(i), 12'h301 + 12'(i), 12'h401 + 12'(i));
            @(negedge clk);
            sample_valid = 1'b0;
            // hi words: 0, 7FE, 7FF, 800 against threshold 800
            check_out($sformatf("R9 stream %0d second", i),
                      (i == 3) ? 12'h403 : ((i == 0) ? 12'h000 : 12'h7FD + i),
                      1, (i == 3) ? 1 : 0);
        end
        @(negedge clk);
        check_out("R10 after stream", 0, 0, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule